// File: doc/BRIEF.md
# Load String Word Sequencer

This unit executes a single load-string-immediate instruction over several cycles. A one-cycle `start` pulse presents a 32-bit instruction word and the value of the base register. The unit first checks the opcode fields. If they are valid, it fetches the requested number of bytes one at a time through a single-outstanding memory read port.

The bytes are packed most-significant first into 32-bit words. Each finished word, and any short final word, is written to consecutive register-file entries through a write port made of an index and the data. A one-cycle `done` pulse closes the operation.

An instruction word that fails decode does not start an operation. It raises `illegal` for one cycle and causes no memory or register traffic.

Top module: `lsw_seq`

## Requirements
- R1: An instruction is valid only when `insn[31:26]` is 31, `insn[10:1]` is 597 and `insn[0]` is 0; 0x7C0004AA is the plain form. A `start` with any other word drives `illegal` high for exactly the next cycle, leaves `busy` low and issues no read and no write.
- R2: The byte count is the field `insn[15:11]`. A value from 1 to 31 means that many bytes, and 0 means 32 bytes. Exactly that many reads are issued.
- R3: The first read address is 0 when the base field `insn[20:16]` is 0, and `base_val` otherwise. Each later read goes to the previous address plus one, wrapping modulo 2^32. Any start alignment is accepted.
- R4: Within each group of four bytes, the first byte read lands in `wdata[31:24]`, the second in `[23:16]`, the third in `[15:8]` and the fourth in `[7:0]`.
- R5: When the count is not a multiple of 4, the final write holds the leftover bytes in its upper lanes and zeros in its unused lower lanes.
- R6: The first write goes to index `insn[25:21]`. Each later write goes to the previous index plus one modulo 32, so 31 is followed by 0. Exactly ceil(count/4) writes occur.
- R7: Every `rd_req` is a one-cycle pulse. No new request is issued until `rd_valid` has answered the previous one, and `rd_addr` stays stable while the unit waits.
- R8: `busy` is high from the cycle after an accepted `start` through the cycle of the final write. `done` is high for exactly one cycle, the cycle right after the final write.
- R9: A `start` that arrives while `busy` is high is ignored. It adds no reads or writes and does not change the running operation.
- R10: The first `rd_req` comes in the cycle after the accepted `start`. A write comes in the cycle after the `rd_valid` that completes its word. When bytes remain, the next `rd_req` is issued in that same cycle as the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (one cycle) |
| insn | input | 32 | Instruction word |
| base_val | input | 32 | Value of the base register |
| rd_req | output | 1 | Byte read request pulse |
| rd_addr | output | 32 | Byte read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Read data byte |
| we | output | 1 | Register write strobe |
| waddr | output | 5 | Register write index |
| wdata | output | 32 | Register write data |
| done | output | 1 | Operation complete pulse |
| illegal | output | 1 | Decode failure pulse |
| busy | output | 1 | Operation in progress |

## Verification
When a word completes and more bytes remain, the register write and the next byte request fall in the same cycle. The scoreboard marks every expected write as either intermediate or final. On each write it checks that `rd_req` is high for an intermediate word and low for the final one, and it checks the address of that overlapping request against its own address queue.

Counts of 7, 32 and 5 bytes with response latencies of one to three cycles make this overlap occur both at 4-byte boundaries and just before a short final word.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  localparam int IDX_W = 5;
  localparam int CNT_W = 6;
  localparam logic [5:0] PRIMARY_OP = 6'd31;
  localparam logic [9:0] EXTENDED_OP = 10'd597;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_FIN} lsw_state_t;

  typedef struct packed {
    logic             ok;
    logic [IDX_W-1:0] rt;
    logic [IDX_W-1:0] ra;
    logic [CNT_W-1:0] nbytes;
  } lsw_dec_t;

  function automatic lsw_dec_t decode_insn(input logic [31:0] w);
    lsw_dec_t d;
    d.ok     = (w[31:26] == PRIMARY_OP) && (w[10:1] == EXTENDED_OP) && !w[0];
    d.rt     = w[25:21];
    d.ra     = w[20:16];
    d.nbytes = (w[15:11] == 5'd0) ? 6'd32 : {1'b0, w[15:11]};
    return d;
  endfunction

  function automatic logic [31:0] merge_byte(input logic [31:0] w,
                                             input logic [1:0] lane,
                                             input logic [7:0] b);
    logic [31:0] r;
    r = w;
    case (lane)
      2'd0: r[31:24] = b;
      2'd1: r[23:16] = b;
      2'd2: r[15:8]  = b;
      default: r[7:0] = b;
    endcase
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] words_for(input logic [CNT_W-1:0] n);
    logic [CNT_W:0] t;
    t = {1'b0, n} + 7'd3;
    return {1'b0, t[CNT_W:2]};
  endfunction

endpackage

// File: rtl/lsw_decode.sv
module lsw_decode
  import lsw_pkg::*;
(
  input  logic [31:0] insn,
  output lsw_dec_t    dec
);
  always_comb dec = decode_insn(insn);
endmodule

// File: rtl/lsw_addr_ctr.sv
module lsw_addr_ctr #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              step,
  output logic [ADDR_W-1:0] ea,
  output logic [CNT_W-1:0]  remaining,
  output logic              last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea        <= '0;
      remaining <= '0;
    end else if (load) begin
      ea        <= load_addr;
      remaining <= load_cnt;
    end else if (step) begin
      ea        <= ea + ADDR_W'(1);
      remaining <= remaining - ONE;
    end
  end

  assign last = (remaining == ONE);

  assert_count_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> remaining != '0);
endmodule

// File: rtl/lsw_packer.sv
module lsw_packer
  import lsw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        take,
  input  logic        flush,
  input  logic [7:0]  byte_in,
  output logic [1:0]  lane,
  output logic [31:0] word_next
);
  logic [31:0] word_q;

  assign word_next = merge_byte(word_q, lane, byte_in);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      word_q <= '0;
      lane   <= '0;
    end else if (take) begin
      if (flush) begin
        word_q <= '0;
        lane   <= '0;
      end else begin
        word_q <= word_next;
        lane   <= lane + 2'd1;
      end
    end
  end

  assert_lane_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && flush) |=> (lane == 2'd0 && word_q == 32'd0));
  assert_lane_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clear) |=> $stable(lane));
endmodule

// File: rtl/lsw_seq.sv
module lsw_seq
  import lsw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       insn,
  input  logic [ADDR_W-1:0] base_val,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              we,
  output logic [IDX_W-1:0]  waddr,
  output logic [31:0]       wdata,
  output logic              done,
  output logic              illegal,
  output logic              busy
);
  lsw_state_t       st;
  lsw_dec_t         dec;
  logic             accept, reject, take, flush, last_byte;
  logic [1:0]       lane;
  logic [31:0]      word_next;
  logic [CNT_W-1:0] remaining, nb_q;
  logic [IDX_W-1:0] dest_q;

  lsw_decode u_dec (.insn(insn), .dec(dec));

  assign accept = start && (st == ST_IDLE) && dec.ok;
  assign reject = start && (st == ST_IDLE) && !dec.ok;
  assign take   = (st == ST_WAIT) && rd_valid;
  assign flush  = take && ((lane == 2'd3) || last_byte);

  lsw_addr_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .load_addr((dec.ra == '0) ? '0 : base_val),
    .load_cnt(dec.nbytes), .step(take),
    .ea(rd_addr), .remaining(remaining), .last(last_byte)
  );

  lsw_packer u_pack (
    .clk(clk), .rst_n(rst_n), .clear(accept), .take(take), .flush(flush),
    .byte_in(rd_data), .lane(lane), .word_next(word_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      dest_q  <= '0;
      nb_q    <= '0;
      we      <= 1'b0;
      waddr   <= '0;
      wdata   <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      we      <= flush;
      done    <= (st == ST_FIN);
      illegal <= reject;
      if (flush) begin
        waddr  <= dest_q;
        wdata  <= word_next;
        dest_q <= dest_q + IDX_W'(1);
      end
      case (st)
        ST_IDLE: if (accept) begin
          st     <= ST_REQ;
          dest_q <= dec.rt;
          nb_q   <= dec.nbytes;
        end
        ST_REQ:  st <= ST_WAIT;
        ST_WAIT: if (take) st <= last_byte ? ST_FIN : ST_REQ;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rd_req = (st == ST_REQ);
  assign busy   = (st != ST_IDLE);

  // Assertion bookkeeping: writes in the current operation, last index written
  logic [CNT_W-1:0] wr_cnt;
  logic [IDX_W-1:0] prev_waddr;
  always_ff @(posedge clk) begin
    if (!rst_n || accept) begin
      wr_cnt     <= '0;
      prev_waddr <= '0;
    end else if (we) begin
      wr_cnt     <= wr_cnt + CNT_W'(1);
      prev_waddr <= waddr;
    end
  end

  assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !rd_req && !we));
  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !rd_valid) |=> $stable(rd_addr));
  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(we) && !we && !busy));
  assert_write_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_cnt == words_for(nb_q)));
  assert_index_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_cnt != '0) |-> (waddr == prev_waddr + IDX_W'(1)));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !take) |=> ($stable(rd_addr) && !illegal));
endmodule

// File: tb/lsw_seq_test.sv
module lsw_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] base_val = '0;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = '0;
  logic        rd_req, we, done, illegal, busy;
  logic [31:0] rd_addr, wdata;
  logic [4:0]  waddr;

  int n_chk = 0;
  int n_bad = 0;
  int mem_lat = 1;
  logic prev_we = 1'b0;

  logic [31:0] exp_addr[$];
  logic [4:0]  exp_idx[$];
  logic [31:0] exp_data[$];
  logic        exp_last[$];
  logic        exp_part[$];

  always #10 clk = ~clk;

  lsw_seq uut (.clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
    .base_val(base_val), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .we(we), .waddr(waddr),
    .wdata(wdata), .done(done), .illegal(illegal), .busy(busy));

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[31:24] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] mk(input logic [4:0] rt, input logic [4:0] ra,
                                     input logic [4:0] nb);
    return {6'd31, rt, ra, nb, 10'd597, 1'b0};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: answers each request after mem_lat cycles
  initial begin
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (rd_req) begin
        automatic logic [31:0] a = rd_addr;
        if (exp_addr.size() == 0) check(0, "R9", "stray read", a, 0);
        else check(a == exp_addr[0], "R3", "read address", a, exp_addr[0]);
        if (exp_addr.size() != 0) void'(exp_addr.pop_front());
        repeat (mem_lat) begin
          @(negedge clk);
          if (rd_req) check(0, "R7", "second outstanding request", 1, 0);
        end
        rd_valid = 1'b1;
        rd_data  = mem_byte(a);
      end
    end
  end

  // monitor: write port and done timing
  initial begin
    forever begin
      @(negedge clk);
      if (we) begin
        if (exp_idx.size() == 0) check(0, "R9", "unexpected write", {27'd0, waddr}, 0);
        else begin
          automatic logic [4:0]  ei = exp_idx.pop_front();
          automatic logic [31:0] ed = exp_data.pop_front();
          automatic logic        el = exp_last.pop_front();
          automatic logic        ep = exp_part.pop_front();
          check(waddr == ei, "R6", "write index", {27'd0, waddr}, {27'd0, ei});
          check(wdata == ed, ep ? "R5" : "R4", "write data", wdata, ed);
          check(rd_req == !el, "R10", "request alongside write", {31'd0, rd_req}, {31'd0, !el});
        end
      end
      if (done) check(prev_we, "R8", "done follows final write", {31'd0, prev_we}, 1);
      prev_we = we;
    end
  end

  task automatic run_op(input logic [31:0] w, input logic [31:0] base, input int lat,
                        input bit inject);
    automatic logic [4:0]  idx = w[25:21];
    automatic int          cnt = (w[15:11] == 0) ? 32 : int'(w[15:11]);
    automatic logic [31:0] a0 = (w[20:16] == 0) ? 32'd0 : base;
    automatic logic [31:0] acc = '0;
    automatic int cyc = 0;
    for (int i = 0; i < cnt; i++) begin
      automatic logic [31:0] a = a0 + 32'(i);
      exp_addr.push_back(a);
      acc = acc | ({24'd0, mem_byte(a)} << (24 - 8 * (i % 4)));
      if ((i % 4) == 3 || i == cnt - 1) begin
        exp_idx.push_back(idx);
        exp_data.push_back(acc);
        exp_last.push_back(i == cnt - 1);
        exp_part.push_back((i == cnt - 1) && (cnt % 4 != 0));
        idx = idx + 5'd1;
        acc = '0;
      end
    end
    mem_lat = lat;
    @(negedge clk);
    start = 1'b1; insn = w; base_val = base;
    @(negedge clk);
    start = 1'b0;
    check(busy && rd_req, "R10", "first request after start", {30'd0, busy, rd_req}, 3);
    while (!done && cyc < 3000) begin
      if (inject && cyc == 4) begin
        start = 1'b1; insn = mk(5'd9, 5'd0, 5'd2); base_val = 32'h5555_0000;
      end else start = 1'b0;
      @(negedge clk);
      if (!done) check(busy, "R8", "busy during operation", {31'd0, busy}, 1);
      cyc++;
    end
    start = 1'b0;
    check(done, "R8", "done reached", {31'd0, done}, 1);
    check(exp_idx.size() == 0, "R6", "writes outstanding at done", exp_idx.size(), 0);
    check(exp_addr.size() == 0, "R2", "reads outstanding at done", exp_addr.size(), 0);
    @(negedge clk);
    check(!done && !busy, "R8", "done single cycle", {30'd0, done, busy}, 0);
    if (inject) begin
      repeat (10) @(negedge clk);
      check(!busy && !rd_req && !we, "R9", "no activity from ignored start",
            {29'd0, busy, rd_req, we}, 0);
    end
  endtask

  task automatic try_bad(input logic [31:0] w, input string what);
    @(negedge clk);
    start = 1'b1; insn = w; base_val = 32'h100;
    @(negedge clk);
    start = 1'b0;
    check(illegal && !busy, "R1", what, {30'd0, illegal, busy}, 2);
    repeat (6) begin
      @(negedge clk);
      check(!illegal && !rd_req && !we && !busy, "R1", {what, " quiet"},
            {28'd0, illegal, rd_req, we, busy}, 0);
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({rd_req, we, done, illegal, busy} == 5'b0, "R8", "reset state",
          {27'd0, rd_req, we, done, illegal, busy}, 0);
    run_op(mk(5'd3, 5'd5, 5'd7), 32'h0000_1000, 1, 0);      // R2 R4 R5
    run_op(mk(5'd28, 5'd2, 5'd0), 32'h0000_2003, 2, 0);     // R2 zero->32, R6 wrap
    run_op(mk(5'd0, 5'd0, 5'd4), 32'hDEAD_0000, 1, 0);      // R3 base field 0
    run_op(mk(5'd10, 5'd1, 5'd5), 32'hFFFF_FFFE, 3, 0);     // R3 address wrap
    run_op(mk(5'd31, 5'd7, 5'd1), 32'h0000_0077, 1, 0);     // R5 single byte, index 31
    run_op(mk(5'd12, 5'd4, 5'd8), 32'h0000_4001, 2, 1);     // R9 start while busy
    try_bad(32'h7C0004AB, "Rc set rejected");
    try_bad(32'h780004AA, "primary opcode rejected");
    try_bad(32'h7C00042A, "extended opcode rejected");
    run_op(32'h7C0004AA, 32'h1234_5678, 1, 0);              // R1 plain form: r0, 32 bytes
    finish_run();
  end
endmodule